// File: doc/BRIEF.md
# Media-Independent Receive Frame Checker

This block receives a nibble stream from a media-independent physical-layer receive interface. Each nibble is qualified by a data-valid input. While the block is idle it searches the preamble for the start-of-frame delimiter. From then on it packs nibbles into bytes, low nibble first, and passes each byte downstream with a start-of-frame marker on the first byte. It runs a CRC-32 over every whole byte and counts the frame length. When data-valid falls it raises an end-of-frame pulse and issues a status word: good, CRC error, runt or alignment error.

When a frame would start while the downstream buffer reports full, nothing of that frame is forwarded and a missed-frame counter is incremented instead. The counter is 8 bits wide and saturates. When it reaches 192 it raises an interrupt flag. A read strobe clears both the counter and the flag. A receiver-enable input gates acceptance of new frames, and its inverse is reported in the status word.

Top module: `mii_rx_checker`

## Requirements
- R1: After reset the outputs outValid, outSof, outEof, statusValid, missIrq, missCount and status are all zero while rxEnable is high.
- R2: A frame starts only where a nibble 0x5 is followed, within one run of rxValid, by a nibble 0xD (the delimiter byte 0xD5, low nibble first). No preamble or delimiter nibble appears on the byte output, and a lone 0xD that is not preceded by 0x5 does not start a frame.
- R3: Nibbles after the delimiter are packed low nibble first. Each byte appears on outByte with outValid high for one cycle, and outSof is high only with the first byte of a frame.
- R4: At the end of a frame, which is the first cycle with rxValid low, outEof and statusValid pulse for one cycle. status bit 0 (good) is 1 only if the CRC register over all whole bytes, bit-reversed, equals 0xC704DD7B, the frame has at least 64 bytes (delimiter excluded, CRC field included) and no odd nibble trails.
- R5: status bit 1 (CRC error) is 1 when the residue check of R4 fails. The CRC is the reflected form of polynomial 0x04C11DB7 with the register preset to all ones.
- R6: status bit 2 (runt) is 1 when fewer than 64 bytes were received.
- R7: A trailing odd nibble is not forwarded and is not included in the CRC. It sets status bit 3 (alignment).
- R8: On the cycle after the delimiter of an accepted frame, status bits 3..0 are cleared. Bit 4 (receiver disabled) always reflects the inverse of rxEnable one cycle later.
- R9: A frame whose delimiter arrives while rxEnable is low is ignored. It produces no bytes, no status and no change to missCount.
- R10: A frame whose delimiter arrives while bufFull is high is dropped. It produces no bytes and no status, and missCount increments by one.
- R11: missIrq goes high on the increment that brings missCount to 192 and stays high until a read strobe.
- R12: missCount saturates at 255.
- R13: missRd clears missCount and missIrq. If an increment occurs in the same cycle, missCount becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive data valid |
| rxNib | input | 4 | Receive nibble |
| rxEnable | input | 1 | Accept new frames when high |
| bufFull | input | 1 | Downstream buffer full |
| missRd | input | 1 | Read strobe that clears the missed-frame counter |
| outByte | output | 8 | Assembled byte |
| outValid | output | 1 | outByte valid |
| outSof | output | 1 | First byte of frame |
| outEof | output | 1 | End-of-frame pulse |
| statusValid | output | 1 | Status word updated this cycle |
| status | output | 5 | {rxDisabled, align, runt, crcErr, good} |
| missCount | output | 8 | Missed-frame count |
| missIrq | output | 1 | Missed-frame threshold flag |

## Verification
The properties assume that rxValid drops for at least one cycle between frames. They also assume that missRd is a single-cycle strobe, and that the drop decision is tied to the delimiter cycle. The stimulus honours this: every frame is followed by idle cycles, and the read strobe is raised for exactly one cycle, once on purpose on the same cycle as a dropped delimiter. Random frames vary in length around the 64-byte boundary, in payload, in corruption and in a trailing odd nibble. The expected bytes and status are recomputed by a separate bit-serial CRC in the bench.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef struct packed {
    logic startFrame;
    logic takeNib;
    logic endFrame;
  } rxCtrl_t;

  localparam int STAT_W    = 5;
  localparam int ST_GOOD   = 0;
  localparam int ST_CRCERR = 1;
  localparam int ST_RUNT   = 2;
  localparam int ST_ALIGN  = 3;
  localparam int ST_RXOFF  = 4;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_MAGIC    = 32'hC704DD7B;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ CRC_POLY_REV) : (x >> 1);
    return x;
  endfunction

endpackage

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [3:0] rxNib,
  input  logic       rxEnable,
  input  logic       bufFull,
  output rxCtrl_t    ctl,
  output logic       missInc
);
  typedef enum logic [1:0] {HUNT, DATA, DROP} rxState_t;
  rxState_t state, stateNxt;
  logic [3:0] prevNib;
  logic sfdHit;

  assign sfdHit = (state == HUNT) && rxValid && (rxNib == 4'hD) && (prevNib == 4'h5);

  always_comb begin
    ctl      = '0;
    missInc  = 1'b0;
    stateNxt = state;
    case (state)
      HUNT: if (sfdHit) begin
        if (!rxEnable) stateNxt = DROP;
        else if (bufFull) begin
          missInc  = 1'b1;
          stateNxt = DROP;
        end else begin
          ctl.startFrame = 1'b1;
          stateNxt       = DATA;
        end
      end
      DATA: if (rxValid) ctl.takeNib = 1'b1;
            else begin
              ctl.endFrame = 1'b1;
              stateNxt     = HUNT;
            end
      DROP: if (!rxValid) stateNxt = HUNT;
      default: stateNxt = HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= HUNT;
      prevNib <= 4'h0;
    end else begin
      state   <= stateNxt;
      prevNib <= rxValid ? rxNib : 4'h0;
    end
  end
endmodule

// File: rtl/mii_rx_datapath.sv
module mii_rx_datapath
  import mii_rx_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtrl_t           ctl,
  input  logic [3:0]        rxNib,
  input  logic              rxEnable,
  output logic [7:0]        outByte,
  output logic              outValid,
  output logic              outSof,
  output logic              outEof,
  output logic              statusValid,
  output logic [STAT_W-1:0] status
);
  localparam logic [31:0]      RESIDUE = rev32(CRC_MAGIC);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);

  logic [3:0]       lowNib;
  logic             phase;
  logic [31:0]      crc;
  logic [LEN_W-1:0] byteCnt;
  logic [7:0]       curByte;
  logic             crcOk, isRunt;

  assign curByte = {rxNib, lowNib};
  assign crcOk   = (crc == RESIDUE);
  assign isRunt  = (byteCnt < LEN_MIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowNib <= '0; phase <= 1'b0; crc <= '1; byteCnt <= '0;
      outByte <= '0; outValid <= 1'b0; outSof <= 1'b0; outEof <= 1'b0;
      statusValid <= 1'b0; status <= '0;
    end else begin
      outValid         <= 1'b0;
      outSof           <= 1'b0;
      outEof           <= 1'b0;
      statusValid      <= 1'b0;
      status[ST_RXOFF] <= !rxEnable;
      if (ctl.startFrame) begin
        phase   <= 1'b0;
        crc     <= '1;
        byteCnt <= '0;
        status[ST_ALIGN:ST_GOOD] <= '0;
      end
      if (ctl.takeNib) begin
        if (!phase) begin
          lowNib <= rxNib;
          phase  <= 1'b1;
        end else begin
          outByte  <= curByte;
          outValid <= 1'b1;
          outSof   <= (byteCnt == '0);
          crc      <= crcByte(crc, curByte);
          if (byteCnt != LEN_MAX) byteCnt <= byteCnt + 1'b1;
          phase    <= 1'b0;
        end
      end
      if (ctl.endFrame) begin
        outEof            <= 1'b1;
        statusValid       <= 1'b1;
        status[ST_GOOD]   <= crcOk && !isRunt && !phase;
        status[ST_CRCERR] <= !crcOk;
        status[ST_RUNT]   <= isRunt;
        status[ST_ALIGN]  <= phase;
      end
    end
  end
endmodule

// File: rtl/mii_rx_miss_cnt.sv
module mii_rx_miss_cnt #(
  parameter int CNT_W  = 8,
  parameter int IRQ_AT = 192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missInc,
  input  logic             missRd,
  output logic [CNT_W-1:0] missCount,
  output logic             missIrq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_IRQ = CNT_W'(IRQ_AT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCount <= '0;
      missIrq   <= 1'b0;
    end else if (missRd) begin
      missCount <= missInc ? CNT_W'(1) : '0;
      missIrq   <= 1'b0;
    end else if (missInc && missCount != CNT_MAX) begin
      missCount <= missCount + 1'b1;
      if (missCount + 1'b1 == CNT_IRQ) missIrq <= 1'b1;
    end
  end
endmodule

// File: rtl/mii_rx_checker.sv
module mii_rx_checker
  import mii_rx_pkg::*;
#(
  parameter int MIN_FRAME   = 64,
  parameter int LEN_W       = 16,
  parameter int MISS_W      = 8,
  parameter int MISS_IRQ_AT = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [3:0]        rxNib,
  input  logic              rxEnable,
  input  logic              bufFull,
  input  logic              missRd,
  output logic [7:0]        outByte,
  output logic              outValid,
  output logic              outSof,
  output logic              outEof,
  output logic              statusValid,
  output logic [STAT_W-1:0] status,
  output logic [MISS_W-1:0] missCount,
  output logic              missIrq
);
  rxCtrl_t ctl;
  logic    missInc;

  mii_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxNib(rxNib),
    .rxEnable(rxEnable), .bufFull(bufFull), .ctl(ctl), .missInc(missInc)
  );

  mii_rx_datapath #(.MIN_FRAME(MIN_FRAME), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxNib(rxNib), .rxEnable(rxEnable),
    .outByte(outByte), .outValid(outValid), .outSof(outSof), .outEof(outEof),
    .statusValid(statusValid), .status(status)
  );

  mii_rx_miss_cnt #(.CNT_W(MISS_W), .IRQ_AT(MISS_IRQ_AT)) miss_i (
    .clk(clk), .rstN(rstN), .missInc(missInc), .missRd(missRd),
    .missCount(missCount), .missIrq(missIrq)
  );
endmodule

// File: rtl/mii_rx_checker_chk.sv
module mii_rx_checker_chk #(
  parameter int CNT_W  = 8,
  parameter int IRQ_AT = 192
) (
  input logic             clk,
  input logic             rstN,
  input logic             missRd,
  input logic             outValid,
  input logic             outSof,
  input logic             outEof,
  input logic             statusValid,
  input logic [CNT_W-1:0] missCount,
  input logic             missIrq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_IRQ = CNT_W'(IRQ_AT);

  // R3
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  // R4
  eof_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> (statusValid && !outValid));

  // R10
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !missRd |=> (missCount >= $past(missCount)));

  // R11
  irq_at_threshold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(missIrq) |-> (missCount == CNT_IRQ));

  // R12
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missCount == CNT_MAX && !missRd) |=> (missCount == CNT_MAX));

  // R13
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    missRd |=> (missCount <= CNT_W'(1) && !missIrq));
endmodule

bind mii_rx_checker mii_rx_checker_chk #(.CNT_W(MISS_W), .IRQ_AT(MISS_IRQ_AT)) chk_i (.*);

// File: tb/mii_rx_checker_tb.sv
module mii_rx_checker_tb_top;
  logic       clk = 1'b0;
  logic       rstN, rxValid, rxEnable, bufFull, missRd;
  logic [3:0] rxNib;
  logic [7:0] outByte, missCount;
  logic       outValid, outSof, outEof, statusValid, missIrq;
  logic [4:0] status;

  always #5 clk = ~clk;

  mii_rx_checker dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxNib(rxNib), .rxEnable(rxEnable),
    .bufFull(bufFull), .missRd(missRd), .outByte(outByte), .outValid(outValid),
    .outSof(outSof), .outEof(outEof), .statusValid(statusValid), .status(status),
    .missCount(missCount), .missIrq(missIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] gotBytes[$];
  int sofBad;
  int statCount;
  logic [4:0] lastStat;
  logic [7:0] frm[0:255];
  int frmLen;

  always @(negedge clk) begin
    if (outValid) begin
      if (outSof != (gotBytes.size() == 0)) sofBad++;
      gotBytes.push_back(outByte);
    end
    if (statusValid) begin
      statCount++;
      lastStat = status;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refFcs(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ frm[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic buildFrame(input int payload, input bit corrupt);
    logic [31:0] f;
    for (int i = 0; i < payload; i++) frm[i] = 8'($urandom);
    f = refFcs(payload);
    for (int i = 0; i < 4; i++) frm[payload+i] = f[8*i +: 8];
    if (corrupt) frm[1] = frm[1] ^ 8'h10;
    frmLen = payload + 4;
  endtask

  task automatic sendNib(input logic [3:0] n);
    rxValid = 1'b1;
    rxNib   = n;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    rxValid = 1'b0;
    rxNib   = 4'h0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBody(input bit odd);
    for (int i = 0; i < frmLen; i++) begin
      sendNib(frm[i][3:0]);
      sendNib(frm[i][7:4]);
    end
    if (odd) sendNib(4'hA);
    idle(4);
  endtask

  task automatic sendFrame(input int preLen, input bit odd);
    repeat (preLen) sendNib(4'h5);
    sendNib(4'hD);
    sendBody(odd);
  endtask

  task automatic checkFrame(input bit corrupt, input bit odd, input string tag);
    int mism = 0;
    logic [3:0] expStat;
    expStat = {odd, frmLen < 64, corrupt, !corrupt && frmLen >= 64 && !odd};
    check(gotBytes.size() == frmLen, {tag, " R3 byte count"}, gotBytes.size(), frmLen);
    for (int i = 0; i < gotBytes.size() && i < frmLen; i++) if (gotBytes[i] != frm[i]) mism++;
    check(mism == 0 && sofBad == 0, {tag, " R3 byte data/sof"}, mism + sofBad, 0);
    check(statCount == 1 && lastStat[3:0] == expStat, {tag, " R4 R5 R6 R7 status"},
          {statCount[7:0], 3'd0, lastStat}, {8'd1, 4'd0, expStat});
  endtask

  task automatic runFrame(input int payload, input bit corrupt, input bit odd, input string tag);
    gotBytes.delete(); sofBad = 0; statCount = 0;
    buildFrame(payload, corrupt);
    sendFrame(15, odd);
    checkFrame(corrupt, odd, tag);
  endtask

  task automatic quickDrop(input bit rdToo);
    sendNib(4'h5);
    missRd = rdToo;
    sendNib(4'hD);
    missRd = 1'b0;
    sendNib(4'h1);
    sendNib(4'h2);
    idle(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; rxValid = 1'b0; rxNib = 4'h0; rxEnable = 1'b1; bufFull = 1'b0; missRd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({outValid, outSof, outEof, statusValid, missIrq} == 0 && missCount == 0 && status == 0,
          "R1 reset outputs", {outValid, outSof, outEof, statusValid, missIrq, missCount, status}, 0);

    // R4 exact 64-byte good frame
    runFrame(60, 0, 0, "good64");
    // R6 runt at 63 bytes
    runFrame(59, 0, 0, "runt63");
    // R8 clear on next start, rxDisabled kept at 0
    check(lastStat[2] == 1'b1, "R6 runt flag held", lastStat, 5'h04);
    gotBytes.delete(); sofBad = 0; statCount = 0;
    buildFrame(70, 0);
    sendNib(4'h5); sendNib(4'h5); sendNib(4'hD);
    check(status == 5'd0, "R8 status cleared at start", status, 0);
    sendBody(0);
    checkFrame(0, 0, "afterClear");
    // R5 corrupted frame
    runFrame(80, 1, 0, "crcBad");
    // R7 odd trailing nibble
    runFrame(66, 0, 1, "odd");
    // R2 lone D then short preamble
    gotBytes.delete(); sofBad = 0; statCount = 0;
    buildFrame(64, 0);
    sendNib(4'h0); sendNib(4'hD); sendNib(4'h3);
    sendFrame(2, 0);
    checkFrame(0, 0, "R2 hunt");

    // R9 receiver disabled
    rxEnable = 1'b0;
    @(negedge clk);
    check(status[4] == 1'b1, "R8 rxDisabled bit", status, 5'h10);
    gotBytes.delete(); statCount = 0;
    buildFrame(60, 0);
    sendFrame(7, 0);
    check(gotBytes.size() == 0 && statCount == 0 && missCount == 0, "R9 disabled frame ignored",
          {gotBytes.size(), statCount, missCount}, 0);
    rxEnable = 1'b1;

    // R10 buffer full drop
    bufFull = 1'b1;
    gotBytes.delete(); statCount = 0;
    sendFrame(7, 0);
    check(gotBytes.size() == 0 && statCount == 0, "R10 dropped frame silent", gotBytes.size() + statCount, 0);
    check(missCount == 1, "R10 count incremented", missCount, 1);

    // R13 read clears
    missRd = 1'b1; @(negedge clk); missRd = 1'b0;
    check(missCount == 0 && !missIrq, "R13 read clears", missCount, 0);

    // R11 threshold
    for (int i = 0; i < 191; i++) quickDrop(0);
    check(missCount == 191 && !missIrq, "R11 below threshold", {missIrq, missCount}, 191);
    quickDrop(0);
    check(missCount == 192 && missIrq, "R11 at threshold", {missIrq, missCount}, 9'h1C0);
    // R12 saturation
    for (int i = 0; i < 66; i++) quickDrop(0);
    check(missCount == 255 && missIrq, "R12 saturates", {missIrq, missCount}, 9'h1FF);
    // R13 coincident read and increment
    quickDrop(1);
    check(missCount == 1 && !missIrq, "R13 read with increment", {missIrq, missCount}, 1);
    bufFull = 1'b0;

    // random frames around the runt boundary
    for (int n = 0; n < 24; n++) begin
      int pl = $urandom_range(50, 90);
      bit cr = ($urandom_range(0, 3) == 0);
      bit od = ($urandom_range(0, 4) == 0);
      runFrame(pl, cr, od, "random");
    end
    finishRun();
  end
endmodule